// File: doc/BRIEF.md
# Converter Sample FIFO with Status

This block buffers converter results on their way to a byte-wide host bus. Each result arrives as a 16-bit word through a write strobe. The upper twelve bits carry the sample and the lower four carry the channel tag. The block stores up to 1024 words in arrival order. The host drains the words through two byte registers: the low byte is read first and the high byte second. Reading the high byte removes the word from the FIFO.

The host controls the block with three bus writes. One sets the enable level, one empties the FIFO, and one clears the interrupt. A status byte reports three conditions: empty, at least half full, and overflow. The interrupt goes high when the fill level crosses the half-full mark. After each interrupt the host reads a block of exactly 512 words. The overflow flag is sticky and marks a word lost because the FIFO was full.

Top module: `adc_sample_fifo`

## Requirements
- R1: After reset the FIFO is disabled and empty, the status byte reads 0x01 and the interrupt output is low.
- R2: Accepted words are returned in the order they were written, with all 16 bits intact (sample in bits 15:4, channel in bits 3:0).
- R3: A write strobe that arrives while the FIFO holds 1024 words, and no pop happens in the same cycle, drops the word and sets the overflow flag. The flag stays set until a flush.
- R4: A bus write to offset 6 sets the enable level: any nonzero byte enables and zero disables. Write strobes that arrive while the FIFO is disabled are ignored and do not set overflow.
- R5: A read of offset 25 returns the status byte: bit 0 is empty, bit 1 is "at least 512 words", bit 2 is overflow, and bits 7:3 are zero. The byte appears on the read data the cycle after the read strobe.
- R6: The interrupt output rises one cycle after the fill level first reaches 512 words. It stays high until a bus write to offset 20, and it does not rise again while the level stays at or above 512.
- R7: A bus write to offset 25 empties the FIFO and clears the overflow flag in one cycle. It leaves the interrupt output unchanged.
- R8: A read of offset 23 returns the low byte of the oldest word, latches that word's high byte and does not pop. A following read of offset 24 returns the latched high byte and pops one word.
- R9: A read of offset 24 while the FIFO is empty changes nothing: no word is lost and the FIFO stays empty.
- R10: When a write strobe and a high-byte read fall in the same cycle on a full FIFO, both take effect. The level stays at 1024, the new word goes to the tail, and no overflow is flagged.
- R11: The FIFO holds exactly 1024 words. The 1024th word is accepted and the 1025th word is treated as an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cvt_wr | input | 1 | Converter result strobe |
| cvt_word | input | 16 | Converter result: sample in 15:4, channel in 3:0 |
| bus_addr | input | 5 | Host register offset |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 8 | Host read data, registered |
| fifo_irq | output | 1 | Half-full interrupt, level |

## Verification
The converter push and the host pop can fall in the same cycle. The hardest case is when the FIFO is already full, because then the push must not be judged as an overflow. The bench fills the FIFO to 1024 words and reads the low byte of the head word. On a single falling edge it then asserts the high-byte read together with a converter strobe. After that it checks four things: the high byte returned, the status byte (half set, overflow clear), the full drain of 1024 words, and that the last word out is the one written during the pop.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // strobes decoded from the host bus in one cycle
  typedef struct packed {
    logic flush;
    logic irq_clr;
    logic pop;
  } host_cmd_t;

  function automatic int unsigned half_mark(int unsigned depth);
    return depth / 2;
  endfunction

  function automatic logic [7:0] status_pack(logic empty, logic half, logic ovf);
    return {5'd0, ovf, half, empty};
  endfunction

  function automatic logic at_or_above(int unsigned level, int unsigned mark);
    return level >= mark;
  endfunction

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned ENTRIES = 1 << AW;

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = 10,
  parameter int unsigned CW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          push_req,
  input  sfifo_pkg::host_cmd_t cmd,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          half,
  output logic          half_q,
  output logic          ovf,
  output logic          irq,
  output logic          push_acc,
  output logic          pop_acc,
  output logic          overflow_ev,
  output logic          half_rise
);
  localparam int unsigned HALF = sfifo_pkg::half_mark(DEPTH);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  assign empty = (count == '0);
  assign full  = (count == FULL_C);
  assign half  = sfifo_pkg::at_or_above(int'(count), HALF);

  // a pop in the same cycle frees the slot the push needs
  assign pop_acc     = cmd.pop && !empty && !cmd.flush;
  assign push_acc    = en && push_req && !cmd.flush && (!full || pop_acc);
  assign overflow_ev = en && push_req && !cmd.flush && full && !pop_acc;
  assign half_rise   = half && !half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (cmd.flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_acc) wptr <= wptr + 1'b1;
      if (pop_acc)  rptr <= rptr + 1'b1;
      if (push_acc && !pop_acc)      count <= count + 1'b1;
      else if (pop_acc && !push_acc) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ovf <= 1'b0;
    else if (cmd.flush)   ovf <= 1'b0;
    else if (overflow_ev) ovf <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      half_q <= half;
      if (half_rise)        irq <= 1'b1;
      else if (cmd.irq_clr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/sfifo_hostport.sv
module sfifo_hostport #(
  parameter int unsigned DW       = 16,
  parameter int unsigned BAW      = 5,
  parameter int unsigned OFF_EN   = 6,
  parameter int unsigned OFF_ICLR = 20,
  parameter int unsigned OFF_LO   = 23,
  parameter int unsigned OFF_HI   = 24,
  parameter int unsigned OFF_STAT = 25
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [BAW-1:0] bus_addr,
  input  logic           bus_wr,
  input  logic [7:0]     bus_wdata,
  input  logic           bus_rd,
  input  logic [DW-1:0]  head_word,
  input  logic           empty,
  input  logic           half,
  input  logic           ovf,
  output logic           en,
  output sfifo_pkg::host_cmd_t cmd,
  output logic [7:0]     bus_rdata
);
  localparam logic [BAW-1:0] A_EN   = BAW'(OFF_EN);
  localparam logic [BAW-1:0] A_ICLR = BAW'(OFF_ICLR);
  localparam logic [BAW-1:0] A_LO   = BAW'(OFF_LO);
  localparam logic [BAW-1:0] A_HI   = BAW'(OFF_HI);
  localparam logic [BAW-1:0] A_STAT = BAW'(OFF_STAT);
  localparam int unsigned    HW     = DW - 8;

  logic [HW-1:0] hold_hi;

  // the flush shares the status offset, on the write side
  assign cmd.flush   = bus_wr && (bus_addr == A_STAT);
  assign cmd.irq_clr = bus_wr && (bus_addr == A_ICLR);
  assign cmd.pop     = bus_rd && (bus_addr == A_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            en <= 1'b0;
    else if (bus_wr && (bus_addr == A_EN)) en <= (bus_wdata != 8'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_hi   <= '0;
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        A_LO: begin
          bus_rdata <= head_word[7:0];
          hold_hi   <= head_word[DW-1:8];
        end
        A_HI:    bus_rdata <= 8'(hold_hi);
        A_STAT:  bus_rdata <= sfifo_pkg::status_pack(empty, half, ovf);
        default: bus_rdata <= 8'd0;
      endcase
    end
  end
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
  parameter int unsigned DEPTH    = 1024,
  parameter int unsigned DW       = 16,
  parameter int unsigned BAW      = 5,
  parameter int unsigned OFF_EN   = 6,
  parameter int unsigned OFF_ICLR = 20,
  parameter int unsigned OFF_LO   = 23,
  parameter int unsigned OFF_HI   = 24,
  parameter int unsigned OFF_STAT = 25
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cvt_wr,
  input  logic [DW-1:0]  cvt_word,
  input  logic [BAW-1:0] bus_addr,
  input  logic           bus_wr,
  input  logic [7:0]     bus_wdata,
  input  logic           bus_rd,
  output logic [7:0]     bus_rdata,
  output logic           fifo_irq
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  sfifo_pkg::host_cmd_t cmd;
  logic          en;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] occ_count;
  logic          empty, full, half, half_q, ovf;
  logic          push_acc, pop_acc, overflow_ev, half_rise;
  logic [DW-1:0] head_word;

  sfifo_hostport #(
    .DW(DW), .BAW(BAW), .OFF_EN(OFF_EN), .OFF_ICLR(OFF_ICLR),
    .OFF_LO(OFF_LO), .OFF_HI(OFF_HI), .OFF_STAT(OFF_STAT)
  ) u_host (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .head_word(head_word),
    .empty(empty), .half(half), .ovf(ovf), .en(en), .cmd(cmd),
    .bus_rdata(bus_rdata)
  );

  sfifo_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .push_req(cvt_wr), .cmd(cmd),
    .wptr(wptr), .rptr(rptr), .count(occ_count), .empty(empty),
    .full(full), .half(half), .half_q(half_q), .ovf(ovf), .irq(fifo_irq),
    .push_acc(push_acc), .pop_acc(pop_acc), .overflow_ev(overflow_ev),
    .half_rise(half_rise)
  );

  sfifo_store #(.DW(DW), .AW(AW)) u_store (
    .clk(clk), .we(push_acc), .waddr(wptr), .wdata(cvt_word),
    .raddr(rptr), .rdata(head_word)
  );
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned CW    = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic          en,
  input logic          flush,
  input logic          irq_clr,
  input logic          push_acc,
  input logic          pop_acc,
  input logic          overflow_ev,
  input logic          empty,
  input logic          half,
  input logic          ovf,
  input logic          irq
);
  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_ev && !flush |=> ovf);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !flush |=> ovf);

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && !ovf);

  assert_disabled_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !pop_acc && !flush |=> $stable(count));

  assert_irq_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(half));

  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !push_acc |=> empty);

  assert_same_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc && pop_acc |=> $stable(count));
endmodule

bind adc_sample_fifo sfifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_sfifo_chk (
  .clk(clk), .rst_n(rst_n), .count(occ_count), .en(en), .flush(cmd.flush),
  .irq_clr(cmd.irq_clr), .push_acc(push_acc), .pop_acc(pop_acc),
  .overflow_ev(overflow_ev), .empty(empty), .half(half), .ovf(ovf),
  .irq(fifo_irq)
);

// File: tb/test_adc_sample_fifo.sv
`timescale 1ns/1ps
module test_adc_sample_fifo;
  localparam int DEPTH = 1024;
  localparam logic [4:0] A_EN = 5'd6, A_ICLR = 5'd20, A_LO = 5'd23,
                         A_HI = 5'd24, A_STAT = 5'd25;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cvt_wr, bus_wr, bus_rd, fifo_irq;
  logic [15:0] cvt_word;
  logic [4:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;

  adc_sample_fifo i_adc_sample_fifo (
    .clk(clk), .rst_n(rst_n), .cvt_wr(cvt_wr), .cvt_word(cvt_word),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .fifo_irq(fifo_irq)
  );

  int total = 0, bad = 0;
  logic [15:0] mdl [0:8191];
  int mh = 0, mt = 0;
  logic en_m = 1'b0;
  int seq = 0;

  function automatic logic [15:0] mk_word(int i);
    logic [11:0] s = 12'(i * 37) ^ 12'hA5C;
    return {s, 4'(i)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic push(logic [15:0] w);
    @(negedge clk);
    cvt_wr = 1'b1; cvt_word = w;
    @(negedge clk);
    cvt_wr = 1'b0;
    if (en_m && (mt - mh) < DEPTH) begin
      mdl[mt % 8192] = w; mt++;
    end
  endtask

  task automatic push_n(int n);
    for (int i = 0; i < n; i++) begin
      push(mk_word(seq)); seq++;
    end
  endtask

  task automatic bwrite(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_word(output logic [15:0] w);
    logic [7:0] lo, hi;
    bread(A_LO, lo);
    bread(A_HI, hi);
    w = {hi, lo};
    if (mt > mh) mh++;
  endtask

  // drains n words and checks each against the model, one check in total
  task automatic drain(string req, int n);
    logic [15:0] w, e;
    int errs = 0;
    logic [15:0] first_bad_a = '0, first_bad_e = '0;
    for (int i = 0; i < n; i++) begin
      e = mdl[mh % 8192];
      read_word(w);
      if (w !== e && errs == 0) begin first_bad_a = w; first_bad_e = e; end
      if (w !== e) errs++;
    end
    chk(req, 32'(first_bad_a), 32'(first_bad_e));
  endtask

  task automatic status_is(string req, logic [7:0] exp);
    logic [7:0] s;
    bread(A_STAT, s);
    chk(req, 32'(s), 32'(exp));
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", 32'(fifo_irq), 32'd0);
    status_is("R1 R5 status after reset", 8'h01);
  endtask

  task automatic t_disabled();
    push_n(3);
    status_is("R4 writes ignored while disabled", 8'h01);
    bwrite(A_EN, 8'h01); en_m = 1'b1;
    bwrite(A_EN, 8'h00); en_m = 1'b0;
    push_n(2);
    status_is("R4 writes ignored after disable", 8'h01);
    bwrite(A_EN, 8'h80); en_m = 1'b1;
  endtask

  task automatic t_order();
    logic [7:0] a, b, hi;
    logic [15:0] e;
    push_n(5);
    status_is("R5 nonempty status", 8'h00);
    e = mdl[mh % 8192];
    bread(A_LO, a);
    bread(A_LO, b);
    chk("R8 low read does not pop", 32'(b), 32'(a));
    chk("R8 low byte value", 32'(a), 32'(e[7:0]));
    bread(A_HI, hi); mh++;
    chk("R8 high byte from latched word", 32'(hi), 32'(e[15:8]));
    drain("R2 order of remaining words", 4);
    status_is("R2 empty after drain", 8'h01);
  endtask

  task automatic t_empty_pop();
    logic [7:0] d;
    logic [15:0] w;
    bread(A_HI, d);
    status_is("R9 empty pop keeps empty", 8'h01);
    push(16'h7E35);
    read_word(w);
    chk("R9 word after empty pop", 32'(w), 32'h7E35);
  endtask

  task automatic t_half_irq();
    push_n(511);
    status_is("R5 below half mark", 8'h00);
    chk("R6 irq low below half", 32'(fifo_irq), 32'd0);
    push_n(1);
    @(negedge clk);
    chk("R6 irq on reaching half", 32'(fifo_irq), 32'd1);
    status_is("R5 half bit", 8'h02);
    push_n(3);
    chk("R6 irq held", 32'(fifo_irq), 32'd1);
    bwrite(A_ICLR, 8'h00);
    chk("R6 irq cleared", 32'(fifo_irq), 32'd0);
    push_n(2);
    chk("R6 no re-rise while above half", 32'(fifo_irq), 32'd0);
    drain("R2 block drain", 517);
    status_is("R2 empty after block", 8'h01);
  endtask

  task automatic t_full_ovf();
    logic [15:0] w;
    push_n(DEPTH);
    status_is("R11 full is not overflow", 8'h02);
    push_n(1);
    status_is("R3 overflow flagged", 8'h06);
    push_n(2);
    status_is("R3 overflow sticky", 8'h06);
    chk("R6 irq before flush", 32'(fifo_irq), 32'd1);
    bwrite(A_STAT, 8'h00); mh = mt;
    status_is("R7 flush empties and clears ovf", 8'h01);
    chk("R7 flush leaves irq", 32'(fifo_irq), 32'd1);
    bwrite(A_ICLR, 8'h00);
    push(16'h1234);
    read_word(w);
    chk("R7 pointers restart after flush", 32'(w), 32'h1234);
  endtask

  task automatic t_same_cycle();
    logic [7:0] lo, hi;
    logic [15:0] e, nw;
    push_n(DEPTH);
    e = mdl[mh % 8192];
    bread(A_LO, lo);
    nw = 16'hBEEF;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = A_HI; cvt_wr = 1'b1; cvt_word = nw;
    @(negedge clk);
    bus_rd = 1'b0; cvt_wr = 1'b0;
    hi = bus_rdata;
    mh++; mdl[mt % 8192] = nw; mt++;
    chk("R10 popped word", 32'({hi, lo}), 32'(e));
    status_is("R10 no overflow with pop", 8'h02);
    drain("R10 R11 full drain with tail word", DEPTH);
    chk("R10 last word is the new one", 32'(mdl[(mt - 1) % 8192]), 32'(nw));
    status_is("R10 empty at end", 8'h01);
    bwrite(A_ICLR, 8'h00);
  endtask

  initial begin
    #(190000 * 5);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cvt_wr = 1'b0; cvt_word = '0; bus_addr = '0;
    bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_order();
    t_empty_pop();
    t_half_irq();
    t_full_ovf();
    t_same_cycle();
    finish_run();
  end
endmodule